// File: doc/BRIEF.md
# SPI Serial Memory Read Engine

This block is the device-side read path of a serial memory with an SPI interface. It works in SPI mode 0. A transfer begins when the host pulls chip select low. The host then clocks in an 8-bit command and a 16-bit byte address. If the command is a read, the engine returns the addressed byte on the serial output, most significant bit first. It keeps returning bytes from consecutive addresses for as long as chip select stays low, and the address wraps from the top of the array back to zero.

The serial pins are asynchronous to the block. They are brought into the system clock domain through synchronizers, and the edges of the serial clock are detected from the synchronized copy. The byte array has fixed contents and is sized by the `AW` parameter (2^AW bytes). The engine recognises commands that modify the array or a status register but does not act on them: they are silently ignored. A direction/enable pair stands in for the tri-state output pad.

Top module: `spi_rd_engine`

## Requirements
- R1: After `rst_ni` is released, `so_oe_o` is 0 and the engine waits for chip select to fall before it accepts a command.
- R2: While `cs_ni` is high, `so_oe_o` is 0 (after the synchronizer delay) and `sclk_i`/`mosi_i` have no effect. Raising `cs_ni` part-way through a transfer abandons it, and the next transfer starts again with a command byte.
- R3: The command is 8 bits, MSB first, sampled on rising `sclk_i` edges after `cs_ni` falls. Value 0x03 starts a read. Any other value keeps `so_oe_o` at 0 until `cs_ni` rises.
- R4: A 16-bit address follows the read command, MSB first. Only its low `AW` bits select the byte; the higher bits are ignored.
- R5: Data leaves on `so_o` MSB first. Each bit is updated after a falling `sclk_i` edge, starting with the falling edge that follows the last address bit. `so_oe_o` is 1 from that point until `cs_ni` rises.
- R6: Once the address phase is over, `mosi_i` is ignored for the rest of the transfer.
- R7: While `cs_ni` stays low, the address steps by one after every 8 data bits, and the next byte follows without a new command.
- R8: After the byte at address 2^AW-1, the next byte comes from address 0, so the whole array can be read in one transfer.
- R9: The byte at array index a holds ((37*a + 0x5B) mod 256) XOR ((a >> 8) mod 256).
- R10: Raising `cs_ni` after a single byte ends the read. A following transfer with a new address returns that address's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial pins are sampled with it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host (mode 0, idles low) |
| mosi_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host; valid while `so_oe_o` is 1 |
| so_oe_o | output | 1 | Output enable for the serial data pad; 0 means high-impedance |

## Verification
The bench sets `AW` to 8, which gives a 256-byte array, and keeps two synchronizer stages. With this size, a single transfer can start at address 5 and run past the top of the array and back, which exercises the full-array wrap of R8, and it can do so in about 25k cycles. The bench also uses a start address whose upper byte is nonzero, which exercises address truncation. The serial clock half period is six system clocks. This leaves margin over the three-cycle path from a pin edge to the updated output, so every bit is sampled just before the host's rising edge.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int CMD_BITS = 8;
  localparam int ADDR_BITS = 16;
  localparam logic [7:0] OP_READ = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rd_state_e;

  // fixed array contents
  function automatic logic [7:0] fill_byte(input int unsigned a);
    logic [31:0] t;
    t = a * 37 + 32'h5B;
    return t[7:0] ^ 8'(a >> 8);
  endfunction
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem import spi_rd_pkg::*; #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] rom [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      assign rom[g] = fill_byte(g);
    end
  endgenerate

  assign rd_data_o = rom[rd_addr_i];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl import spi_rd_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          so_o,
  output logic          so_oe_o,
  output rd_state_e     state_o
);
  localparam int SH_W = (AW > CMD_BITS) ? AW : CMD_BITS;
  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

  rd_state_e        state_q;
  logic [SH_W-2:0]  shift_q;
  logic [SH_W-1:0]  shift_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [AW-1:0]    addr_q;
  logic             so_q, oe_q;

  assign shift_nx = {shift_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
      bit_q   <= 3'd7;
      addr_q  <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!cs_act_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_CMD;
          cnt_q   <= '0;
        end
        ST_CMD: if (rise_i) begin
          shift_q <= shift_nx[SH_W-2:0];
          if (cnt_q == CMD_LAST) begin
            cnt_q   <= '0;
            state_q <= (shift_nx[7:0] == OP_READ) ? ST_ADDR : ST_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: if (rise_i) begin
          shift_q <= shift_nx[SH_W-2:0];
          if (cnt_q == ADDR_LAST) begin
            addr_q  <= shift_nx[AW-1:0];  // upper address bits dropped
            bit_q   <= 3'd7;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (fall_i) begin
          so_q  <= rd_data_i[bit_q];
          oe_q  <= 1'b1;
          bit_q <= bit_q - 1'b1;
          if (bit_q == 3'd0) addr_q <= addr_q + 1'b1;  // wraps at 2^AW
        end
        default: ;  // ST_SKIP: wait for cs release
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign so_o      = so_q;
  assign so_oe_o   = oe_q;
  assign state_o   = state_q;
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine import spi_rd_pkg::*; #(
  parameter int AW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic so_o,
  output logic so_oe_o
);
  logic [2:0]    pin_s;
  logic          cs_act, sclk_s, mosi_s, sclk_d_q;
  logic          sclk_rise, sclk_fall;
  rd_state_e     state;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  spi_rd_sync #(
    .W(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (pin_s)
  );

  assign cs_act = ~pin_s[2];
  assign sclk_s = pin_s[1];
  assign mosi_s = pin_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;

  spi_rd_ctrl #(.AW(AW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .mosi_i   (mosi_s),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .so_o     (so_o),
    .so_oe_o  (so_oe_o),
    .state_o  (state)
  );

  spi_rd_mem #(.AW(AW)) u_mem (
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/spi_rd_engine_chk.sv
module spi_rd_engine_chk import spi_rd_pkg::*; #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          so_o,
  input logic          so_oe_o,
  input logic          cs_act,
  input logic          sclk_fall,
  input rd_state_e     state,
  input logic [AW-1:0] rd_addr
);
  p_released_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !so_oe_o);

  p_cs_pin_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !so_oe_o);

  p_bad_cmd_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP) |-> !so_oe_o);

  p_oe_in_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (state == ST_DATA));

  p_so_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> $past(sclk_fall));

  // R7/R8: address only holds or steps by one (modulo 2^AW)
  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_DATA) && ($past(state) == ST_DATA)) |->
      ((rd_addr == $past(rd_addr)) || (rd_addr == AW'($past(rd_addr) + 1'b1))));

  p_addr_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_DATA) && ($past(state) == ST_DATA) && (rd_addr != $past(rd_addr)))
      |-> $past(sclk_fall));
endmodule

bind spi_rd_engine spi_rd_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_spi_rd_engine.sv
module sim_spi_rd_engine;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic so, so_oe;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_rd_engine #(.AW(AW)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_n),
    .sclk_i (sclk),
    .mosi_i (mosi),
    .so_o   (so),
    .so_oe_o(so_oe)
  );

  // R9 contents, index reduced to AW bits (R4)
  function automatic logic [7:0] exp_byte(input int unsigned a);
    int unsigned m;
    logic [31:0] t;
    m = a % DEPTH;
    t = m * 37 + 91;
    return t[7:0] ^ 8'(m >> 8);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic din, output logic dout, output logic oe);
    mosi = din;
    wait_clk(HALF);
    dout = so;
    oe = so_oe;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic begin_xfer();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_xfer();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, output logic oe_any);
    logic d, o;
    oe_any = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_cycle(v[i], d, o);
      oe_any |= o;
    end
  endtask

  task automatic recv_byte(input logic [7:0] noise, output logic [7:0] b, output logic oe_all);
    logic d, o;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(noise[i], d, o);
      b[i] = d;
      oe_all &= o;
    end
  endtask

  task automatic read_seq(input string req, input logic [15:0] addr, input int n,
                          input logic [7:0] noise);
    logic oe_any, oe_all;
    logic [7:0] b;
    begin_xfer();
    send_bits(16'h0003, 8, oe_any);
    send_bits(addr, 16, oe_any);
    for (int k = 0; k < n; k++) begin
      recv_byte(noise ^ 8'(k), b, oe_all);
      check(req, {7'd0, oe_all, b}, {7'd0, 1'b1, exp_byte(32'(addr) + k)});
    end
    end_xfer();
  endtask

  task automatic t_reset();
    check("R1 oe after reset", {15'd0, so_oe}, 16'd1 - 16'd1);
    read_seq("R1 first read", 16'h0012, 1, 8'h00);
  endtask

  task automatic t_basic();
    read_seq("R5 single byte", 16'h0001, 1, 8'h00);
    read_seq("R9 contents", 16'h00FF, 1, 8'h00);
    read_seq("R9 contents", 16'h0080, 2, 8'h00);
  endtask

  task automatic t_increment();
    read_seq("R7 auto increment", 16'h0040, 6, 8'h00);
  endtask

  task automatic t_noise();
    read_seq("R6 mosi ignored", 16'h0020, 4, 8'h03);
    read_seq("R6 mosi ignored", 16'h0021, 3, 8'hA5);
  endtask

  task automatic t_high_addr();
    read_seq("R4 upper bits ignored", 16'hAB33, 3, 8'h00);
  endtask

  task automatic t_wrap();
    read_seq("R8 wrap", 16'(DEPTH - 2), 4, 8'h00);
    read_seq("R8 full array", 16'h0005, DEPTH + 2, 8'h5A);
  endtask

  task automatic t_bad_cmd();
    logic oe_any;
    begin_xfer();
    send_bits(16'h000B, 8, oe_any);
    send_bits(16'h1234, 16, oe_any);
    check("R3 opcode 0x0B quiet", {15'd0, oe_any}, 16'd0);
    send_bits(16'h0003, 8, oe_any);
    send_bits(16'h0010, 16, oe_any);
    check("R3 no restart without cs", {15'd0, oe_any}, 16'd0);
    end_xfer();
    begin_xfer();
    send_bits(16'h0002, 8, oe_any);
    send_bits(16'hFFFF, 16, oe_any);
    check("R3 opcode 0x02 quiet", {15'd0, oe_any}, 16'd0);
    end_xfer();
    read_seq("R3 read after bad opcode", 16'h0044, 2, 8'h00);
  endtask

  task automatic t_cs_high();
    logic oe_any;
    send_bits(16'h0003, 8, oe_any);
    send_bits(16'h0050, 16, oe_any);
    send_bits(16'h00FF, 8, oe_any);
    check("R2 sclk with cs high", {15'd0, oe_any}, 16'd0);
    begin_xfer();
    send_bits(16'h0000, 4, oe_any);
    end_xfer();
    read_seq("R2 abandoned command", 16'h0077, 2, 8'h00);
  endtask

  task automatic t_single_end();
    logic oe_any, oe_all;
    logic [7:0] b;
    begin_xfer();
    send_bits(16'h0003, 8, oe_any);
    send_bits(16'h0030, 16, oe_any);
    recv_byte(8'h00, b, oe_all);
    check("R10 one byte", {7'd0, oe_all, b}, {7'd0, 1'b1, exp_byte(32'h30)});
    end_xfer();
    check("R10 oe after cs rise", {15'd0, so_oe}, 16'd0);
    read_seq("R10 fresh address", 16'h0090, 1, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_basic();
    t_increment();
    t_noise();
    t_high_addr();
    t_bad_cmd();
    t_cs_high();
    t_single_end();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule